// File: doc/BRIEF.md
# Register Readiness Interlock

This block keeps one ready flag for each architectural register of an in-order pipeline and uses those flags to hold the decode stage. The decode stage presents the instruction it holds: up to two source register numbers and one destination register number, each with its own enable, plus a request line saying that an instruction is present. If any enabled register other than register 0 is flagged not ready, the block raises `stall` and the instruction stays in decode.

An instruction issues on a clock edge where `dec_req` is high and `stall` is low. On that edge, if its destination is enabled and non-zero, the destination's flag drops. When the producing instruction later writes back, the writeback port raises that register's flag again. The destination is checked as well as the sources. A second write to a register that still has a producer in flight therefore waits too. The only state kept is one bit per register.

Top module: `reg_ready_interlock`

## Requirements
- R1: While reset is low, every register flag is set. After reset, an instruction reading any registers raises no stall.
- R2: When an instruction issues with `dec_dst_en`=1 and a non-zero `dec_dst_idx`, that register's flag drops on the same edge. From the next cycle, a request that reads it as an enabled source stalls.
- R3: A request whose enabled, non-zero destination is flagged not ready stalls, even when none of its sources are.
- R4: A field whose enable is 0 never causes a stall, whatever its index.
- R5: A writeback (`wb_en`=1) sets the flag of `wb_idx` on the clock edge. In the cycle of the writeback itself, `stall` still reflects the old flag.
- R6: If a writeback and an issuing instruction's destination name the same register on the same edge, the flag ends up not ready.
- R7: A stalled request clears no flag. Only the edge on which it actually issues does.
- R8: Register 0 is always ready. Issuing with destination 0 clears nothing, and reading or writing 0 never stalls.
- R9: `stall` is low whenever `dec_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_req | input | 1 | Decode holds an instruction that wants to issue |
| dec_src_a_en | input | 1 | First source field is used |
| dec_src_a_idx | input | IW | First source register number |
| dec_src_b_en | input | 1 | Second source field is used |
| dec_src_b_idx | input | IW | Second source register number |
| dec_dst_en | input | 1 | Instruction writes a destination |
| dec_dst_idx | input | IW | Destination register number |
| wb_en | input | 1 | A result is written back this cycle |
| wb_idx | input | IW | Register number being written back |
| stall | output | 1 | Hold the decode instruction this cycle |

IW is clog2(NUM_REGS), which is 5 by default.

## Verification
On every cycle, assertions check the following:
- the reset state of the flags;
- that an issue clears its destination flag and a writeback sets its flag;
- that a clear wins over a set on the same register;
- that the flags stay frozen while a request is held with no writeback;
- that a not-ready destination forces a stall;
- that register 0 never blocks.

Some behaviour only the bench scenarios can show. One is the same-cycle view, where a reader still stalls while its producer writes back. Another is that disabled fields are ignored. The bench also compares `stall` with a model that counts outstanding writes per register, over long random instruction streams.

// File: rtl/rri_pkg.sv
package rri_pkg;

  // Slots checked per decode instruction; the position in the slot arrays.
  typedef enum int unsigned {
    CHK_SRC_A = 0,
    CHK_SRC_B = 1,
    CHK_DST   = 2
  } chk_slot_e;

  localparam int unsigned CHK_SLOTS = 3;

  // A slot takes part in the check only when enabled and not register 0.
  function automatic logic slot_live(input logic en, input logic idx_is_zero);
    return en && !idx_is_zero;
  endfunction

endpackage

// File: rtl/rri_idx_decoder.sv
module rri_idx_decoder #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IW = $clog2(NUM_REGS)
) (
  input  logic                en,
  input  logic [IW-1:0]       idx,
  output logic [NUM_REGS-1:0] vec
);

  // Register 0 never gets a strobe: it is hardwired ready.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_line
    if (r == 0) begin : g_zero
      assign vec[r] = 1'b0;
    end else begin : g_live
      assign vec[r] = en && (idx == IW'(r));
    end
  end

endmodule

// File: rtl/rri_vbit_array.sv
module rri_vbit_array #(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] set_vec,
  input  logic [NUM_REGS-1:0] clr_vec,
  output logic [NUM_REGS-1:0] vbits
);

  // Next value of one flag: a clear from an issuing writer beats a set.
  function automatic logic next_flag(input logic cur, input logic set_i, input logic clr_i);
    if (clr_i)      return 1'b0;
    else if (set_i) return 1'b1;
    else            return cur;
  endfunction

  logic unused_r0;
  assign unused_r0 = set_vec[0] ^ clr_vec[0];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_flag
    if (r == 0) begin : g_zero
      assign vbits[r] = 1'b1;
    end else begin : g_reg
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b1;
        else        flag_q <= next_flag(flag_q, set_vec[r], clr_vec[r]);
      end
      assign vbits[r] = flag_q;

      assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vec[r] |=> !vbits[r]);

      assert_set_on_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec[r] && !clr_vec[r]) |=> vbits[r]);
    end
  end

endmodule

// File: rtl/rri_hazard_check.sv
module rri_hazard_check #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned SLOTS    = 3,
  localparam int unsigned IW = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0]       vbits,
  input  logic [SLOTS-1:0][IW-1:0]  slot_idx,
  input  logic [SLOTS-1:0]          slot_en,
  output logic [SLOTS-1:0]          slot_busy,
  output logic                      any_busy
);
  import rri_pkg::*;

  // A slot blocks when it is live and its register is not ready.
  function automatic logic blocked(input logic en, input logic [IW-1:0] idx,
                                   input logic [NUM_REGS-1:0] flags);
    return slot_live(en, idx == '0) && !flags[idx];
  endfunction

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_busy[s] = blocked(slot_en[s], slot_idx[s], vbits);
  end

  assign any_busy = |slot_busy;

endmodule

// File: rtl/reg_ready_interlock.sv
module reg_ready_interlock #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_req,
  input  logic          dec_src_a_en,
  input  logic [IW-1:0] dec_src_a_idx,
  input  logic          dec_src_b_en,
  input  logic [IW-1:0] dec_src_b_idx,
  input  logic          dec_dst_en,
  input  logic [IW-1:0] dec_dst_idx,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  output logic          stall
);
  import rri_pkg::*;

  logic [CHK_SLOTS-1:0][IW-1:0] chk_idx;
  logic [CHK_SLOTS-1:0]         chk_en;
  logic [CHK_SLOTS-1:0]         slot_busy;
  logic                         hazard;
  logic                         issue_fire;
  logic [NUM_REGS-1:0]          clr_vec;
  logic [NUM_REGS-1:0]          set_vec;
  logic [NUM_REGS-1:0]          vbits;

  assign chk_idx[CHK_SRC_A] = dec_src_a_idx;
  assign chk_idx[CHK_SRC_B] = dec_src_b_idx;
  assign chk_idx[CHK_DST]   = dec_dst_idx;
  assign chk_en[CHK_SRC_A]  = dec_src_a_en;
  assign chk_en[CHK_SRC_B]  = dec_src_b_en;
  assign chk_en[CHK_DST]    = dec_dst_en;

  rri_hazard_check #(.NUM_REGS(NUM_REGS), .SLOTS(CHK_SLOTS)) u_check (
    .vbits     (vbits),
    .slot_idx  (chk_idx),
    .slot_en   (chk_en),
    .slot_busy (slot_busy),
    .any_busy  (hazard)
  );

  assign stall      = dec_req && hazard;
  assign issue_fire = dec_req && !hazard;

  // Clear strobe only on a real issue; set strobe from writeback.
  rri_idx_decoder #(.NUM_REGS(NUM_REGS)) u_clr_dec (
    .en  (issue_fire && dec_dst_en),
    .idx (dec_dst_idx),
    .vec (clr_vec)
  );

  rri_idx_decoder #(.NUM_REGS(NUM_REGS)) u_set_dec (
    .en  (wb_en),
    .idx (wb_idx),
    .vec (set_vec)
  );

  rri_vbit_array #(.NUM_REGS(NUM_REGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .vbits   (vbits)
  );

  // ---------------- assertions ----------------
  assert_reset_all_ready_R1: assert property (@(posedge clk)
    !rst_n |=> (&vbits));

  assert_issue_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !stall && dec_dst_en && dec_dst_idx != '0)
      |=> !vbits[$past(dec_dst_idx)]);

  assert_dst_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && dec_dst_en && dec_dst_idx != '0 && !vbits[dec_dst_idx]) |-> stall);

  assert_hold_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !wb_en) |=> (vbits == $past(vbits)));

  assert_zero_never_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && (!dec_src_a_en || dec_src_a_idx == '0)
             && (!dec_src_b_en || dec_src_b_idx == '0)
             && (!dec_dst_en   || dec_dst_idx   == '0)) |-> !stall);

  assert_busy_slot_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ((slot_busy & chk_en) != '0));

endmodule

// File: tb/test_reg_ready_interlock.sv
`timescale 1ns/1ps
module test_reg_ready_interlock;
  localparam int NR = 32;
  localparam int IW = $clog2(NR);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_req = 1'b0;
  logic dec_src_a_en = 1'b0, dec_src_b_en = 1'b0, dec_dst_en = 1'b0, wb_en = 1'b0;
  logic [IW-1:0] dec_src_a_idx = '0, dec_src_b_idx = '0, dec_dst_idx = '0, wb_idx = '0;
  logic stall;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int outstanding [NR];

  always #2 clk = ~clk;

  reg_ready_interlock #(.NUM_REGS(NR)) i_reg_ready_interlock (
    .clk(clk), .rst_n(rst_n), .dec_req(dec_req),
    .dec_src_a_en(dec_src_a_en), .dec_src_a_idx(dec_src_a_idx),
    .dec_src_b_en(dec_src_b_en), .dec_src_b_idx(dec_src_b_idx),
    .dec_dst_en(dec_dst_en), .dec_dst_idx(dec_dst_idx),
    .wb_en(wb_en), .wb_idx(wb_idx), .stall(stall)
  );

  function automatic bit pend(input bit en, input int idx);
    return en && idx != 0 && outstanding[idx] > 0;
  endfunction

  task automatic drive(input bit req, input bit ae, input int a, input bit be, input int b,
                       input bit de, input int d, input bit we, input int w);
    dec_req = req;
    dec_src_a_en = ae; dec_src_a_idx = IW'(a);
    dec_src_b_en = be; dec_src_b_idx = IW'(b);
    dec_dst_en = de;   dec_dst_idx = IW'(d);
    wb_en = we;        wb_idx = IW'(w);
  endtask

  // Check stall for the driven inputs, advance the model, move to the next negedge.
  task automatic step(input string tag);
    bit exp;
    bit fire;
    #1;
    exp = dec_req && (pend(dec_src_a_en, int'(dec_src_a_idx)) ||
                      pend(dec_src_b_en, int'(dec_src_b_idx)) ||
                      pend(dec_dst_en,   int'(dec_dst_idx)));
    checks++;
    if (stall !== exp) begin
      errors++;
      $display("FAIL %s stall actual=%0b expected=%0b at %0t", tag, stall, exp, $time);
    end
    fire = dec_req && !exp;
    if (wb_en && outstanding[int'(wb_idx)] > 0) outstanding[int'(wb_idx)]--;
    if (fire && dec_dst_en && dec_dst_idx != '0) outstanding[int'(dec_dst_idx)]++;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) outstanding[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: after reset, reads of any registers do not stall
    for (int i = 0; i < NR; i += 5) begin
      drive(1, 1, i, 1, (i + 1) % NR, 0, 9, 0, 0);
      step("R1");
    end
    // R2: issue writer of r7, then a reader of r7 stalls
    drive(1, 0, 0, 0, 0, 1, 7, 0, 0);  step("R2");
    drive(1, 1, 7, 0, 0, 1, 12, 0, 0); step("R2");
    // R7: the held instruction did not clear r12
    drive(1, 1, 12, 0, 0, 0, 0, 0, 0); step("R7");
    // R5: writeback cycle still stalls, next cycle clears
    drive(1, 1, 7, 0, 0, 1, 12, 1, 7); step("R5");
    drive(1, 1, 7, 0, 0, 1, 12, 0, 0); step("R5");
    // R3: WAW on r12 stalls
    drive(1, 0, 0, 0, 0, 1, 12, 0, 0); step("R3");
    // R4: disabled fields naming busy r12 ignored
    drive(1, 0, 12, 0, 12, 0, 12, 0, 0); step("R4");
    // R9: no request, no stall even with busy r12 named
    drive(0, 1, 12, 1, 12, 1, 12, 1, 12); step("R9");
    drive(1, 1, 12, 0, 0, 0, 0, 0, 0); step("R5");
    // R6: writeback to r21 and issue with destination r21 on one edge
    drive(1, 0, 0, 0, 0, 1, 21, 1, 21); step("R6");
    drive(1, 0, 0, 1, 21, 0, 0, 0, 0);  step("R6");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 21);  step("R6");
    // R8: register 0 as destination and source
    drive(1, 1, 0, 1, 0, 1, 0, 0, 0); step("R8");
    drive(1, 1, 0, 1, 0, 1, 0, 0, 0); step("R8");
    drive(1, 0, 0, 0, 0, 0, 0, 1, 0); step("R8");

    // Random streams on a small register window to provoke hazards (R2, R3)
    for (int n = 0; n < 4000; n++) begin
      int pq[$];
      int w;
      bit we;
      for (int i = 0; i < NR; i++) if (outstanding[i] > 0) pq.push_back(i);
      we = (pq.size() > 0) && ($urandom_range(0, 9) < 4);
      w = we ? pq[$urandom_range(0, pq.size() - 1)] : int'($urandom_range(0, NR - 1));
      drive($urandom_range(0, 3) != 0,
            $urandom_range(0, 1), $urandom_range(0, 7),
            $urandom_range(0, 1), $urandom_range(0, 7),
            $urandom_range(0, 3) != 0, $urandom_range(0, 7),
            we, w);
      step((n % 2 == 0) ? "R2" : "R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule